// File: doc/BRIEF.md
# Dual Line Instruction Prefetch Buffer

This block sits between an instruction memory port and a variable-length instruction decoder. It holds two 16-byte line buffers used in ping-pong fashion. While the decoder drains bytes from one line, the other line is fetched from memory, so the fetch side runs on its own and keeps both buffers occupied whenever memory keeps up. Each cycle the decoder sees a small window of contiguous bytes, starting at the current fetch address, with a count of how many of them are valid. It reports back how many bytes it used. The window is formed across the seam between the two buffers, so an instruction that straddles two lines is still seen in one piece.

A taken branch arrives as a redirect carrying the new fetch address. The redirect discards both buffers and any line request in flight, and fetching restarts at the line that holds the target. The bytes in front of an unaligned target are never shown. Every line request carries a small epoch tag. A response whose tag belongs to an epoch before the latest redirect is thrown away.

Top module: `ipf_dual_buffer`

## Requirements
- R1: After reset the window is empty (dec_count = 0), dec_pc equals START_ADDR, and a line request for the aligned START_ADDR with tag 0 is offered.
- R2: dec_count equals the smaller of WIN_BYTES and the number of unconsumed bytes held. Lane j (bits 8j+7:8j of dec_bytes) carries the byte at address dec_pc + j, including when that byte lies in the second buffer. Lanes at or above dec_count read as zero.
- R3: Without a redirect, dec_pc advances by dec_take on every clock, and the consumed bytes leave the window.
- R4: A line request is offered in every cycle in which at least one buffer is empty and no request is awaiting its response. A buffer drained by the decoder is therefore requested again on the following cycle if the port is idle.
- R5: At most one request is outstanding. An offered request keeps its address and tag unchanged until the memory accepts it.
- R6: Request addresses are multiples of 16 and follow consecutive lines: each accepted request is followed by one for the next 16-byte line.
- R7: A redirect empties both buffers and cancels any outstanding request. In the next cycle dec_count is 0, dec_pc equals the target, and the offered request is the target's aligned line.
- R8: After a redirect to an unaligned target, the first non-empty window starts with the byte at the target address. The bytes in front of it in that line are never shown.
- R9: The request tag increments by one (modulo 2^TAG_W) on every redirect. A response is accepted only while a request is outstanding and its tag equals the current tag. Any other response changes nothing.
- R10: A redirect takes priority over a response and a consume in the same cycle, and neither of them affects the state after the flush.
- R11: dec_take must not exceed dec_count. Taking exactly dec_count bytes is legal and advances dec_pc by that amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Fetch address redirect for a taken branch |
| redir_addr | input | ADDR_W | Redirect target byte address |
| mem_req_valid | output | 1 | Line request offered |
| mem_req_ready | input | 1 | Memory accepts the offered request |
| mem_req_addr | output | ADDR_W | 16-byte aligned line address |
| mem_req_tag | output | TAG_W | Epoch tag of the request |
| mem_rsp_valid | input | 1 | Line response present |
| mem_rsp_tag | input | TAG_W | Tag echoed with the response |
| mem_rsp_data | input | 8*LINE_BYTES | Line data, lowest address in the low byte |
| dec_bytes | output | 8*WIN_BYTES | Decoder window, lane 0 at dec_pc |
| dec_count | output | $clog2(WIN_BYTES+1) | Number of valid window lanes |
| dec_pc | output | ADDR_W | Address of window lane 0 |
| dec_take | input | $clog2(WIN_BYTES+1) | Bytes consumed this cycle |

## Verification
Refill and consume overlap all the time: a response can land in the empty buffer in the same cycle that the decoder drains the other one. The harder overlap is a redirect that lands together with a line response and a non-zero take. In its last phase the bench deliberately raises redirects in cycles where the memory model is presenting a response, and it drains the full window each cycle. Judgment comes from a behavioural model, kept as a line count and a read offset, that applies the flush first and drops the same-cycle response and consume. The bench then checks that the cycle afterwards shows an empty window at the target and a fresh tagged request. Stale responses from the abandoned epoch keep arriving after the flush and must leave the model's count and the window untouched.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

   // state of the single request slot
   typedef enum logic [0:0] {
      SLOT_IDLE = 1'b0,
      SLOT_WAIT = 1'b1
   } slot_state_e;

   function automatic int unsigned imin(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/ipf_fill_ctrl.sv
module ipf_fill_ctrl
   import ipf_pkg::*;
#(
   parameter int              ADDR_W     = 32,
   parameter int              LINE_BYTES = 16,
   parameter int              TAG_W      = 3,
   parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic [ADDR_W-1:0] flush_addr_i,
   input  logic [1:0]        full_i,
   input  logic              head_i,
   input  logic              req_ready_i,
   input  logic              rsp_valid_i,
   input  logic [TAG_W-1:0]  rsp_tag_i,
   output logic              req_valid_o,
   output logic [ADDR_W-1:0] req_addr_o,
   output logic [TAG_W-1:0]  req_tag_o,
   output logic              fill_en_o,
   output logic              fill_idx_o
);

   localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(LINE_BYTES - 1);
   localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(LINE_BYTES);

   slot_state_e       slot_q;
   logic [TAG_W-1:0]  epoch_q;
   logic [ADDR_W-1:0] next_line_q;
   logic              target_q;
   logic              req_fire;

   assign req_valid_o = (slot_q == SLOT_IDLE) && !(full_i[0] && full_i[1]);
   assign req_fire    = req_valid_o && req_ready_i;
   assign req_addr_o  = next_line_q;
   assign req_tag_o   = epoch_q;
   assign fill_en_o   = rsp_valid_i && (slot_q == SLOT_WAIT) &&
                        (rsp_tag_i == epoch_q) && !flush_i;
   assign fill_idx_o  = target_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q      <= SLOT_IDLE;
         epoch_q     <= '0;
         next_line_q <= START_ADDR & LINE_MASK;
         target_q    <= 1'b0;
      end else if (flush_i) begin
         slot_q      <= SLOT_IDLE;
         epoch_q     <= epoch_q + 1'b1;
         next_line_q <= flush_addr_i & LINE_MASK;
      end else if (req_fire) begin
         slot_q      <= SLOT_WAIT;
         next_line_q <= next_line_q + LINE_STEP;
         // the oldest empty slot: head when both are empty, else the other one
         target_q    <= full_i[head_i] ? ~head_i : head_i;
      end else if (fill_en_o) begin
         slot_q      <= SLOT_IDLE;
      end
   end

endmodule

// File: rtl/ipf_line_store.sv
module ipf_line_store #(
   parameter int LINE_BYTES = 16,
   parameter int TAKE_W     = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush_i,
   input  logic [$clog2(LINE_BYTES)-1:0] flush_off_i,
   input  logic                        fill_en_i,
   input  logic                        fill_idx_i,
   input  logic [8*LINE_BYTES-1:0]     fill_data_i,
   input  logic [TAKE_W-1:0]           take_i,
   output logic [16*LINE_BYTES-1:0]    lines_o,
   output logic [1:0]                  full_o,
   output logic                        head_o,
   output logic [$clog2(LINE_BYTES)-1:0] rd_off_o
);

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = 8 * LINE_BYTES;
   localparam int SUM_W  = OFF_W + 1;

   logic [1:0]       full_q, full_d;
   logic             head_q;
   logic [OFF_W-1:0] off_q;
   logic [SUM_W-1:0] off_sum;
   logic             wrap;

   assign off_sum = {1'b0, off_q} + SUM_W'(take_i);
   assign wrap    = off_sum >= SUM_W'(LINE_BYTES);

   always_comb begin
      full_d = full_q;
      if (wrap)      full_d[head_q]     = 1'b0;
      if (fill_en_i) full_d[fill_idx_i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= '0;
         head_q <= 1'b0;
         off_q  <= '0;
      end else if (flush_i) begin
         full_q <= '0;
         head_q <= 1'b0;
         off_q  <= flush_off_i;
      end else begin
         full_q <= full_d;
         if (wrap) begin
            head_q <= ~head_q;
            off_q  <= OFF_W'(off_sum - SUM_W'(LINE_BYTES));
         end else begin
            off_q  <= OFF_W'(off_sum);
         end
      end
   end

   genvar b;
   generate
      for (b = 0; b < 2; b++) begin : g_buf
         logic [LINE_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               data_q <= '0;
            else if (fill_en_i && !flush_i && (fill_idx_i == 1'(b)))
               data_q <= fill_data_i;
         end
         assign lines_o[b*LINE_W +: LINE_W] = data_q;
      end
   endgenerate

   assign full_o   = full_q;
   assign head_o   = head_q;
   assign rd_off_o = off_q;

endmodule

// File: rtl/ipf_window.sv
module ipf_window
   import ipf_pkg::*;
#(
   parameter int LINE_BYTES = 16,
   parameter int WIN_BYTES  = 4,
   parameter bit ZERO_IDLE  = 1'b1
) (
   input  logic [16*LINE_BYTES-1:0]      lines_i,
   input  logic [1:0]                    full_i,
   input  logic                          head_i,
   input  logic [$clog2(LINE_BYTES)-1:0] rd_off_i,
   output logic [8*WIN_BYTES-1:0]        win_o,
   output logic [$clog2(WIN_BYTES+1)-1:0] cnt_o
);

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int LINE_W = 8 * LINE_BYTES;
   localparam int AV_W   = OFF_W + 2;
   localparam int CNT_W  = $clog2(WIN_BYTES + 1);

   logic [2*LINE_W-1:0] seq;
   logic [AV_W-1:0]     avail;
   logic                head_full, tail_full;

   // older line in the low half, younger above it
   assign seq = head_i ? {lines_i[0 +: LINE_W], lines_i[LINE_W +: LINE_W]}
                       : lines_i;

   assign head_full = full_i[head_i];
   assign tail_full = full_i[~head_i];

   always_comb begin
      avail = '0;
      if (head_full) begin
         avail = AV_W'(LINE_BYTES) - AV_W'(rd_off_i);
         if (tail_full) avail = avail + AV_W'(LINE_BYTES);
      end
   end

   assign cnt_o = CNT_W'(imin(int'(avail), WIN_BYTES));

   genvar j;
   generate
      for (j = 0; j < WIN_BYTES; j++) begin : g_lane
         logic [OFF_W:0] pos;
         logic [7:0]     raw;
         assign pos = {1'b0, rd_off_i} + (OFF_W+1)'(j);
         assign raw = seq[int'(pos)*8 +: 8];
         if (ZERO_IDLE) begin : g_zero
            assign win_o[j*8 +: 8] = (CNT_W'(j) < cnt_o) ? raw : 8'h00;
         end else begin : g_raw
            assign win_o[j*8 +: 8] = raw;
         end
      end
   endgenerate

endmodule

// File: rtl/ipf_dual_buffer.sv
module ipf_dual_buffer #(
   parameter int                ADDR_W     = 32,
   parameter int                LINE_BYTES = 16,
   parameter int                WIN_BYTES  = 4,
   parameter int                TAG_W      = 3,
   parameter bit                ZERO_IDLE  = 1'b1,
   parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             redir_valid,
   input  logic [ADDR_W-1:0]                redir_addr,
   output logic                             mem_req_valid,
   input  logic                             mem_req_ready,
   output logic [ADDR_W-1:0]                mem_req_addr,
   output logic [TAG_W-1:0]                 mem_req_tag,
   input  logic                             mem_rsp_valid,
   input  logic [TAG_W-1:0]                 mem_rsp_tag,
   input  logic [8*LINE_BYTES-1:0]          mem_rsp_data,
   output logic [8*WIN_BYTES-1:0]           dec_bytes,
   output logic [$clog2(WIN_BYTES+1)-1:0]   dec_count,
   output logic [ADDR_W-1:0]                dec_pc,
   input  logic [$clog2(WIN_BYTES+1)-1:0]   dec_take
);

   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int CNT_W  = $clog2(WIN_BYTES + 1);

   generate
      if (LINE_BYTES != (1 << OFF_W)) begin : g_bad_line
         $error("LINE_BYTES must be a power of two");
      end
      if (WIN_BYTES < 3 || WIN_BYTES > LINE_BYTES) begin : g_bad_win
         $error("WIN_BYTES must lie between 3 and LINE_BYTES");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least one");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("ADDR_W must exceed the line offset width");
      end
   endgenerate

   logic [16*LINE_BYTES-1:0] lines;
   logic [1:0]               full;
   logic                     head;
   logic [OFF_W-1:0]         rd_off;
   logic                     fill_en, fill_idx;
   logic [CNT_W-1:0]         take_eff;
   logic [ADDR_W-1:0]        pc_q;

   assign take_eff = redir_valid ? '0 : dec_take;

   ipf_fill_ctrl #(
      .ADDR_W    (ADDR_W),
      .LINE_BYTES(LINE_BYTES),
      .TAG_W     (TAG_W),
      .START_ADDR(START_ADDR)
   ) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (redir_valid),
      .flush_addr_i(redir_addr),
      .full_i      (full),
      .head_i      (head),
      .req_ready_i (mem_req_ready),
      .rsp_valid_i (mem_rsp_valid),
      .rsp_tag_i   (mem_rsp_tag),
      .req_valid_o (mem_req_valid),
      .req_addr_o  (mem_req_addr),
      .req_tag_o   (mem_req_tag),
      .fill_en_o   (fill_en),
      .fill_idx_o  (fill_idx)
   );

   ipf_line_store #(
      .LINE_BYTES(LINE_BYTES),
      .TAKE_W    (CNT_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (redir_valid),
      .flush_off_i(redir_addr[OFF_W-1:0]),
      .fill_en_i  (fill_en),
      .fill_idx_i (fill_idx),
      .fill_data_i(mem_rsp_data),
      .take_i     (take_eff),
      .lines_o    (lines),
      .full_o     (full),
      .head_o     (head),
      .rd_off_o   (rd_off)
   );

   ipf_window #(
      .LINE_BYTES(LINE_BYTES),
      .WIN_BYTES (WIN_BYTES),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_win (
      .lines_i (lines),
      .full_i  (full),
      .head_i  (head),
      .rd_off_i(rd_off),
      .win_o   (dec_bytes),
      .cnt_o   (dec_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           pc_q <= START_ADDR;
      else if (redir_valid) pc_q <= redir_addr;
      else                  pc_q <= pc_q + ADDR_W'(take_eff);
   end

   assign dec_pc = pc_q;

endmodule

// File: rtl/ipf_dual_buffer_chk.sv
module ipf_dual_buffer_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int WIN_BYTES  = 4,
   parameter int TAG_W      = 3
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           redir_valid,
   input logic [ADDR_W-1:0]              redir_addr,
   input logic                           mem_req_valid,
   input logic                           mem_req_ready,
   input logic [ADDR_W-1:0]              mem_req_addr,
   input logic [TAG_W-1:0]               mem_req_tag,
   input logic [$clog2(WIN_BYTES+1)-1:0] dec_count,
   input logic [ADDR_W-1:0]              dec_pc,
   input logic [$clog2(WIN_BYTES+1)-1:0] dec_take
);

   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int CNT_W = $clog2(WIN_BYTES + 1);

   // R11
   take_within_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !redir_valid |-> dec_take <= dec_count);

   // R2
   window_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_count <= CNT_W'(WIN_BYTES));

   // R6
   req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr[OFF_W-1:0] == '0);

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready && !redir_valid |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag));

   // R5
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready && !redir_valid |=> !mem_req_valid);

   // R7
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> dec_count == '0 && dec_pc == $past(redir_addr));

   // R3
   pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !redir_valid |=> dec_pc == $past(dec_pc) + ADDR_W'($past(dec_take)));

   // R9
   tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> mem_req_tag == $past(mem_req_tag) + 1'b1);

endmodule

bind ipf_dual_buffer ipf_dual_buffer_chk #(
   .ADDR_W    (ADDR_W),
   .LINE_BYTES(LINE_BYTES),
   .WIN_BYTES (WIN_BYTES),
   .TAG_W     (TAG_W)
) u_chk (.*);

// File: tb/sim_ipf_dual_buffer.sv
module sim_ipf_dual_buffer;

   localparam int AW = 32;
   localparam int LB = 16;
   localparam int WB = 4;
   localparam int TW = 3;
   localparam int CW = $clog2(WB + 1);
   localparam int N_CYC = 4000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          redir_valid;
   logic [AW-1:0] redir_addr;
   logic          mem_req_valid, mem_req_ready;
   logic [AW-1:0] mem_req_addr;
   logic [TW-1:0] mem_req_tag;
   logic          mem_rsp_valid;
   logic [TW-1:0] mem_rsp_tag;
   logic [8*LB-1:0] mem_rsp_data;
   logic [8*WB-1:0] dec_bytes;
   logic [CW-1:0] dec_count;
   logic [AW-1:0] dec_pc;
   logic [CW-1:0] dec_take;

   always #10 clk = ~clk;

   ipf_dual_buffer u0 (
      .clk(clk), .rst_n(rst_n),
      .redir_valid(redir_valid), .redir_addr(redir_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
      .mem_rsp_data(mem_rsp_data),
      .dec_bytes(dec_bytes), .dec_count(dec_count),
      .dec_pc(dec_pc), .dec_take(dec_take)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   function automatic logic [7:0] byte_at(input logic [AW-1:0] a);
      logic [AW-1:0] t;
      t = (a * 32'd29) ^ (a >> 4) ^ (a >> 11);
      return t[7:0];
   endfunction

   function automatic logic [8*LB-1:0] line_of(input logic [AW-1:0] base);
      logic [8*LB-1:0] d;
      for (int i = 0; i < LB; i++) d[i*8 +: 8] = byte_at(base + AW'(i));
      return d;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reference state: lines held, offset in oldest line, pc, request slot
   int            m_lines, m_off;
   logic [AW-1:0] m_pc, m_next;
   bit            m_pend;
   logic [TW-1:0] m_tag;

   // memory model, in order
   logic [AW-1:0] q_addr[$];
   logic [TW-1:0] q_tag[$];
   int            q_due[$];
   int            last_due;

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4 watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int  exp_avail, exp_cnt, since_redir, taken_total;
      bit  p_redir, p_busy, p_hold, p_full_take, wait_first;
      logic [AW-1:0] p_tgt, p_addr, p_pc, first_tgt;
      int  p_take;
      logic [8*WB-1:0] exp_win;
      bit  exp_rv, rdy, rv, rd, accept;
      int  lat, tk;

      rst_n = 1'b0; redir_valid = 1'b0; redir_addr = '0; mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0; mem_rsp_tag = '0; mem_rsp_data = '0; dec_take = '0;
      m_lines = 0; m_off = 0; m_pc = '0; m_next = '0; m_pend = 0; m_tag = '0;
      last_due = 0; since_redir = 100; taken_total = 0;
      p_redir = 0; p_busy = 0; p_hold = 0; p_full_take = 0; wait_first = 0;
      p_tgt = '0; p_addr = '0; p_pc = '0; p_take = 0; first_tgt = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk(dec_count == 0, "R1", "reset count", 64'(dec_count), 0);
      chk(dec_pc == 0, "R1", "reset pc", 64'(dec_pc), 0);
      chk(mem_req_valid == 1'b1, "R1", "reset req_valid", 64'(mem_req_valid), 1);
      chk(mem_req_addr == 0 && mem_req_tag == 0, "R1", "reset req addr/tag",
          64'(mem_req_addr), 0);

      for (int cyc = 0; cyc < N_CYC; cyc++) begin
         @(negedge clk);
         exp_avail = (m_lines == 0) ? 0 : m_lines * LB - m_off;
         exp_cnt   = (exp_avail < WB) ? exp_avail : WB;
         exp_rv    = !m_pend && (m_lines < 2);
         for (int j = 0; j < WB; j++)
            exp_win[j*8 +: 8] = (j < exp_cnt) ? byte_at(m_pc + AW'(j)) : 8'h00;

         chk(int'(dec_count) == exp_cnt, "R2", "count", 64'(dec_count), 64'(exp_cnt));
         chk(dec_bytes == exp_win, "R2", "window bytes", 64'(dec_bytes), 64'(exp_win));
         chk(dec_pc == m_pc, "R3", "pc", 64'(dec_pc), 64'(m_pc));
         chk(mem_req_valid == exp_rv, "R4", "req_valid", 64'(mem_req_valid), 64'(exp_rv));
         if (exp_rv) begin
            chk(mem_req_addr == m_next, "R6", "req_addr", 64'(mem_req_addr), 64'(m_next));
            chk(mem_req_tag == m_tag, "R9", "req_tag", 64'(mem_req_tag), 64'(m_tag));
         end
         if (p_redir) begin
            chk(dec_count == 0 && dec_pc == p_tgt, "R7", "after redirect pc",
                64'(dec_pc), 64'(p_tgt));
            if (p_busy)
               chk(dec_count == 0 && mem_req_valid && mem_req_addr == (p_tgt & ~32'(LB-1)),
                   "R10", "redirect with response/take", 64'(mem_req_addr),
                   64'(p_tgt & ~32'(LB-1)));
         end
         if (wait_first && dec_count != 0) begin
            chk(dec_bytes[7:0] == byte_at(first_tgt) && dec_pc == first_tgt, "R8",
                "first byte after unaligned target", 64'(dec_bytes[7:0]),
                64'(byte_at(first_tgt)));
            wait_first = 0;
         end
         if (p_hold)
            chk(mem_req_valid && mem_req_addr == p_addr, "R5", "held request",
                64'(mem_req_addr), 64'(p_addr));
         if (p_full_take)
            chk(dec_pc == p_pc + AW'(p_take), "R11", "full window take",
                64'(dec_pc), 64'(p_pc + AW'(p_take)));

         // stimulus
         rdy = (cyc < 1000) ? 1'b1 : 1'($urandom % 2);
         lat = (cyc < 1000) ? 1 : 1 + int'($urandom % 4);
         tk  = (cyc >= 3500) ? exp_cnt : int'($urandom % (exp_cnt + 1));

         rv = 0;
         if (q_addr.size() > 0 && q_due[0] <= cyc) begin
            rv = 1;
            mem_rsp_tag  = q_tag[0];
            mem_rsp_data = line_of(q_addr[0]);
            void'(q_addr.pop_front()); void'(q_tag.pop_front()); void'(q_due.pop_front());
         end else begin
            mem_rsp_data = '0;
         end
         mem_rsp_valid = rv;

         rd = 0;
         if (cyc >= 2000 && since_redir >= 2) begin
            if (cyc < 3500) rd = ($urandom % 10) == 0;
            else            rd = (rv && ($urandom % 3) == 0) || (($urandom % 25) == 0);
         end
         redir_valid = rd;
         redir_addr  = $urandom;
         if (($urandom % 4) == 0) redir_addr = redir_addr & ~32'(LB - 1);
         mem_req_ready = rdy;
         dec_take = CW'(tk);

         if (mem_req_valid && rdy) begin
            q_addr.push_back(mem_req_addr);
            q_tag.push_back(mem_req_tag);
            last_due = (cyc + lat > last_due + 1) ? cyc + lat : last_due + 1;
            q_due.push_back(last_due);
         end

         // record for next-cycle checks
         p_redir     = rd;
         p_busy      = rd && (rv || tk > 0);
         p_tgt       = redir_addr;
         p_hold      = !rd && mem_req_valid && !rdy;
         p_addr      = mem_req_addr;
         p_full_take = !rd && tk > 0 && tk == exp_cnt;
         p_pc        = m_pc;
         p_take      = tk;

         // reference update for the coming edge
         if (rd) begin
            m_lines = 0; m_off = int'(redir_addr % LB); m_pc = redir_addr;
            m_pend = 0; m_tag = m_tag + 1'b1; m_next = redir_addr & ~32'(LB - 1);
            since_redir = 0;
            wait_first = (redir_addr % LB) != 0;
            first_tgt  = redir_addr;
         end else begin
            accept = rv && m_pend && (mem_rsp_tag == m_tag);
            m_pc  = m_pc + AW'(tk);
            m_off = m_off + tk;
            taken_total += tk;
            if (m_off >= LB) begin
               m_lines--; m_off -= LB;
            end
            if (accept) begin
               m_lines++; m_pend = 0;
            end
            if (exp_rv && rdy) begin
               m_pend = 1; m_next = m_next + AW'(LB);
            end
            since_redir++;
         end
      end

      @(negedge clk);
      chk(taken_total >= 1500, "R4", "bytes delivered overall", 64'(taken_total), 1500);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule